// File: doc/BRIEF.md
# Step-Down Converter Switch Timing Controller

This block produces the on/off timing for the high-side switch of a fixed-frequency, peak current-mode step-down converter. It runs from a fast system clock, and every time value it uses is a count of clock cycles. Each switching period starts with a strobe, and the switch turns on at that point. The switch turns off when an external peak-current comparator trips. Two rules limit when this can happen. The switch must stay on for a minimum time after it turns on. It must also stay off for a minimum time before the period ends. The second rule sets the largest duty cycle the block can produce.

The block has three protection and low-load behaviours:
- **Skipped pulse.** If the comparator is already tripped at the end of a period, the next period starts with no conduction pulse.
- **Foldback.** While the short-circuit request is high, the period is stretched by a fixed divide factor.
- **Hiccup.** If the overcurrent flag is seen in several consecutive periods, switching stops for a long timed interval. A new period then starts.

Analog sensing, slope compensation, the error amplifier and bootstrap regulation are handled elsewhere.

Top module: `buck_pwm_timer`

## Requirements
- R1: With foldback low, the cycle-start strobe is high for one clock every PERIOD clocks (default 118).
- R2: In a period that is not skipped, the gate is high from the strobe cycle onward. If the comparator is first seen high in period cycle t (the strobe cycle is cycle 0), the gate is low from cycle t+1. The pulse is therefore t+1 cycles long, within the limits of R3 and R4.
- R3: A pulse lasts at least MIN_ON cycles (default 9). A trip that arrives earlier is held and ends the pulse as soon as the minimum has passed.
- R4: The gate is low for at least the last MIN_OFF cycles (default 9) of every period. With no trip, the pulse is therefore exactly period length minus MIN_OFF.
- R5: If the comparator input is high in the last cycle of a period, the next period has no gate pulse. The skip flag is high for exactly one clock, in that period's strobe cycle.
- R6: If the foldback request is high in the last cycle of a period, the next period is PERIOD×FOLD_DIV clocks long (default 590). Its pulse is still capped by MIN_OFF.
- R7: If the current-limit flag is seen in OC_PERSIST consecutive periods, the hiccup flag rises in the cycle after the last of those periods ends. While it is high, the gate and the strobe stay low.
- R8: The hiccup flag stays high for exactly HICCUP_CYC clocks. A new period strobe follows one clock after it falls.
- R9: Driving enable low forces the gate low in the same cycle, stops the strobes, and clears any hiccup interval at the next clock edge. One clock after enable is sampled high again, a new period starts with its strobe.
- R10: While reset is asserted, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable, active high |
| trip | input | 1 | Peak-current comparator output |
| fold_req | input | 1 | Short-circuit or foldback request |
| ilim | input | 1 | Current-limit flag |
| gate | output | 1 | High-side switch drive |
| cyc_start | output | 1 | One-clock strobe at the start of each period |
| skip | output | 1 | One-clock flag for a period without a pulse |
| hiccup | output | 1 | High during the timed hiccup shutdown |

## Verification
A wrong period counter or a wrongly latched length shows up at the next strobe. The distance between strobes moves away from 118 or 590 within one period. Faults in the on-window logic show up as a wrong pulse width by the end of the same period: a lost trip latch, a wrong cap, or a skip decision taken from the wrong cycle. Faults in the overcurrent counter or the hiccup timer take longer to appear. They show up as a hiccup that starts in the wrong period, or as a wrong number of quiet cycles before switching resumes.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

   typedef enum logic [0:0] {
      HC_WATCH = 1'b0,
      HC_HOLD  = 1'b1
   } hc_state_e;

   // Bits needed to hold the value v (at least one).
   function automatic int unsigned bkp_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/bkp_period_gen.sv
module bkp_period_gen
   import bkp_pkg::*;
#(
   parameter int unsigned PERIOD   = 118,
   parameter int unsigned FOLD_DIV = 5,
   parameter int unsigned PW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          fold_req,
   output logic          going,
   output logic [PW-1:0] ph,
   output logic [PW-1:0] len_q,
   output logic          last,
   output logic          new_per
);

   logic [PW-1:0] len_sel;

   generate
      if (FOLD_DIV == 1) begin : g_plain
         assign len_sel = PW'(PERIOD);
      end else begin : g_fold
         assign len_sel = fold_req ? PW'(PERIOD * FOLD_DIV) : PW'(PERIOD);
      end
   endgenerate

   assign last    = going && (ph == len_q - PW'(1));
   assign new_per = run && (!going || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         going <= 1'b0;
         ph    <= '0;
         len_q <= PW'(PERIOD);
      end else if (!run) begin
         going <= 1'b0;
         ph    <= '0;
      end else if (new_per) begin
         going <= 1'b1;
         ph    <= '0;
         len_q <= len_sel;
      end else begin
         ph    <= ph + PW'(1);
      end
   end

endmodule

// File: rtl/bkp_pulse_seq.sv
module bkp_pulse_seq
   import bkp_pkg::*;
#(
   parameter int unsigned MIN_ON  = 9,
   parameter int unsigned MIN_OFF = 9,
   parameter int unsigned PW      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          new_per,
   input  logic [PW-1:0] ph,
   input  logic [PW-1:0] len_q,
   input  logic          trip,
   output logic          on_q,
   output logic          skip_q
);

   logic trip_lat;
   logic trip_any;
   logic on_done;
   logic cap_hit;
   logic end_now;

   assign trip_any = trip_lat || trip;
   assign on_done  = ph >= PW'(MIN_ON - 1);
   assign cap_hit  = ph == (len_q - PW'(MIN_OFF + 1));
   assign end_now  = on_q && ((trip_any && on_done) || cap_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q     <= 1'b0;
         skip_q   <= 1'b0;
         trip_lat <= 1'b0;
      end else if (!run) begin
         on_q     <= 1'b0;
         skip_q   <= 1'b0;
         trip_lat <= 1'b0;
      end else if (new_per) begin
         on_q     <= !trip;
         skip_q   <= trip;
         trip_lat <= 1'b0;
      end else begin
         skip_q <= 1'b0;
         if (end_now) begin
            on_q <= 1'b0;
         end
         if (on_q && trip) begin
            trip_lat <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bkp_hiccup_ctl.sv
module bkp_hiccup_ctl
   import bkp_pkg::*;
#(
   parameter int unsigned OC_PERSIST = 4,
   parameter int unsigned HICCUP_CYC = 1600000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic going,
   input  logic last,
   input  logic ilim,
   output logic hic_q,
   output logic hic_enter
);

   localparam int unsigned OCW = bkp_bits(OC_PERSIST);
   localparam int unsigned HW  = bkp_bits(HICCUP_CYC);

   hc_state_e      state;
   logic           oc_seen;
   logic           hit;
   logic [OCW-1:0] oc_cnt;
   logic [HW-1:0]  timer;

   assign hit       = oc_seen || ilim;
   assign hic_enter = (state == HC_WATCH) && en && going && last && hit &&
                      (oc_cnt == OCW'(OC_PERSIST - 1));
   assign hic_q     = (state == HC_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= HC_WATCH;
         oc_seen <= 1'b0;
         oc_cnt  <= '0;
         timer   <= '0;
      end else if (!en) begin
         state   <= HC_WATCH;
         oc_seen <= 1'b0;
         oc_cnt  <= '0;
         timer   <= '0;
      end else begin
         case (state)
            HC_WATCH: begin
               if (going) begin
                  if (last) begin
                     oc_seen <= 1'b0;
                     if (hic_enter) begin
                        state  <= HC_HOLD;
                        timer  <= HW'(HICCUP_CYC - 1);
                        oc_cnt <= '0;
                     end else if (hit) begin
                        oc_cnt <= oc_cnt + OCW'(1);
                     end else begin
                        oc_cnt <= '0;
                     end
                  end else if (ilim) begin
                     oc_seen <= 1'b1;
                  end
               end
            end
            HC_HOLD: begin
               if (timer == '0) begin
                  state <= HC_WATCH;
               end else begin
                  timer <= timer - HW'(1);
               end
            end
            default: state <= HC_WATCH;
         endcase
      end
   end

endmodule

// File: rtl/buck_pwm_timer.sv
module buck_pwm_timer
   import bkp_pkg::*;
#(
   parameter int unsigned PERIOD     = 118,
   parameter int unsigned MIN_ON     = 9,
   parameter int unsigned MIN_OFF    = 9,
   parameter int unsigned FOLD_DIV   = 5,
   parameter int unsigned OC_PERSIST = 4,
   parameter int unsigned HICCUP_CYC = 1600000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic trip,
   input  logic fold_req,
   input  logic ilim,
   output logic gate,
   output logic cyc_start,
   output logic skip,
   output logic hiccup
);

   localparam int unsigned LEN_MAX = PERIOD * FOLD_DIV;
   localparam int unsigned PW      = bkp_bits(LEN_MAX);

   generate
      if (MIN_ON < 1 || MIN_OFF < 1) begin : g_bad_window
         $error("buck_pwm_timer: minimum windows must be at least one cycle");
      end
      if (MIN_ON + MIN_OFF >= PERIOD) begin : g_bad_period
         $error("buck_pwm_timer: PERIOD must exceed MIN_ON + MIN_OFF");
      end
      if (FOLD_DIV < 1) begin : g_bad_div
         $error("buck_pwm_timer: FOLD_DIV must be at least one");
      end
      if (OC_PERSIST < 1 || HICCUP_CYC < 1) begin : g_bad_hiccup
         $error("buck_pwm_timer: hiccup parameters must be at least one");
      end
   endgenerate

   logic          run;
   logic          going;
   logic [PW-1:0] ph;
   logic [PW-1:0] len_q;
   logic          last;
   logic          new_per;
   logic          on_q;
   logic          skip_q;
   logic          hic_q;
   logic          hic_enter;

   assign run = en && !hic_q && !hic_enter;

   bkp_period_gen #(
      .PERIOD   (PERIOD),
      .FOLD_DIV (FOLD_DIV),
      .PW       (PW)
   ) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .fold_req (fold_req),
      .going    (going),
      .ph       (ph),
      .len_q    (len_q),
      .last     (last),
      .new_per  (new_per)
   );

   bkp_pulse_seq #(
      .MIN_ON  (MIN_ON),
      .MIN_OFF (MIN_OFF),
      .PW      (PW)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .new_per (new_per),
      .ph      (ph),
      .len_q   (len_q),
      .trip    (trip),
      .on_q    (on_q),
      .skip_q  (skip_q)
   );

   bkp_hiccup_ctl #(
      .OC_PERSIST (OC_PERSIST),
      .HICCUP_CYC (HICCUP_CYC)
   ) u_hiccup (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .going     (going),
      .last      (last),
      .ilim      (ilim),
      .hic_q     (hic_q),
      .hic_enter (hic_enter)
   );

   assign gate      = on_q && en && !hic_q;
   assign cyc_start = going && (ph == '0);
   assign skip      = skip_q;
   assign hiccup    = hic_q;

endmodule

// File: rtl/bkp_checker.sv
module bkp_checker #(
   parameter int unsigned MIN_ON     = 9,
   parameter int unsigned MIN_OFF    = 9,
   parameter int unsigned HICCUP_CYC = 1600000
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic gate,
   input logic cyc_start,
   input logic skip,
   input logic hiccup
);

   logic [31:0] on_len;
   logic [31:0] off_len;
   logic [31:0] hic_len;
   logic        g_prev;
   logic        en_prev;
   logic        h_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_len  <= '0;
         off_len <= MIN_OFF;
         hic_len <= '0;
         g_prev  <= 1'b0;
         en_prev <= 1'b0;
         h_prev  <= 1'b0;
      end else begin
         g_prev  <= gate;
         en_prev <= en;
         h_prev  <= hiccup;
         on_len  <= gate ? on_len + 32'd1 : 32'd0;
         hic_len <= hiccup ? hic_len + 32'd1 : 32'd0;
         if (!en) begin
            off_len <= MIN_OFF;
         end else if (gate) begin
            off_len <= '0;
         end else if (off_len < MIN_OFF) begin
            off_len <= off_len + 32'd1;
         end
      end
   end

   // R3
   a_r3_min_on: assert property (@(posedge clk) disable iff (!rst_n)
      (g_prev && !gate && en && en_prev) |-> (on_len >= MIN_ON));

   // R4
   a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !g_prev && en) |-> (off_len >= MIN_OFF));

   // R5
   a_r5_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> (cyc_start && !gate));

   // R2
   a_r2_start_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !skip && en && !hiccup) |-> gate);

   // R7
   a_r7_hiccup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup |-> (!gate && !cyc_start));

   // R8
   a_r8_hiccup_len: assert property (@(posedge clk) disable iff (!rst_n)
      (h_prev && !hiccup && en && en_prev) |-> (hic_len == HICCUP_CYC));

endmodule

bind buck_pwm_timer bkp_checker #(
   .MIN_ON     (MIN_ON),
   .MIN_OFF    (MIN_OFF),
   .HICCUP_CYC (HICCUP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .gate      (gate),
   .cyc_start (cyc_start),
   .skip      (skip),
   .hiccup    (hiccup)
);

// File: tb/sim_buck_pwm_timer.sv
`timescale 1ns/1ps
module sim_buck_pwm_timer;

   localparam int PER  = 118;
   localparam int MON  = 9;
   localparam int MOFF = 9;
   localparam int DIV  = 5;
   localparam int OCP  = 3;
   localparam int HIC  = 2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic trip = 1'b0;
   logic fold = 1'b0;
   logic ilim = 1'b0;
   logic gate, cyc_start, skip, hiccup;

   always #5 clk = ~clk;

   buck_pwm_timer #(
      .PERIOD(PER), .MIN_ON(MON), .MIN_OFF(MOFF), .FOLD_DIV(DIV),
      .OC_PERSIST(OCP), .HICCUP_CYC(HIC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .fold_req(fold),
      .ilim(ilim), .gate(gate), .cyc_start(cyc_start), .skip(skip),
      .hiccup(hiccup)
   );

   typedef struct {
      int    len;
      int    wid;
      int    skc;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;
   bit   mon_on = 1'b0;
   bit   open = 1'b0;
   int   m_len, m_w, m_sk;
   int   cur_len = PER;
   bit   cur_skip = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // Monitor: measures each period and compares against the queue.
   always @(negedge clk) begin
      if (!mon_on) begin
         open = 1'b0;
      end else if (cyc_start) begin
         if (open) begin
            if (q.size() == 0) begin
               chk(1'b0, "R1", "unexpected period", m_len, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(m_len == e.len, (e.len == PER) ? "R1" : "R6", "period length", m_len, e.len);
               chk(m_w == e.wid, e.tag, "pulse width", m_w, e.wid);
               chk(m_sk == e.skc, "R5", "skip cycles", m_sk, e.skc);
            end
         end
         open  = 1'b1;
         m_len = 1;
         m_w   = int'(gate);
         m_sk  = int'(skip);
      end else if (open) begin
         m_len++;
         m_w  += int'(gate);
         m_sk += int'(skip);
      end
   end

   // Driver: one switching period, pushing its expected result.
   task automatic run_period(input int trip_at, input bit skip_next,
                             input bit fold_next, input string tag);
      exp_t e;
      int   w;
      do @(negedge clk); while (!cyc_start);
      trip = 1'b0;
      fold = fold_next;
      if (cur_skip) w = 0;
      else if (trip_at < 0) w = cur_len - MOFF;
      else begin
         w = trip_at + 1;
         if (w < MON) w = MON;
         if (w > cur_len - MOFF) w = cur_len - MOFF;
      end
      e.len = cur_len;
      e.wid = w;
      e.skc = cur_skip ? 1 : 0;
      e.tag = tag;
      q.push_back(e);
      for (int k = 0; k < cur_len; k++) begin
         trip = ((k == trip_at) && !cur_skip) || (skip_next && (k == cur_len - 1));
         if (k < cur_len - 1) @(negedge clk);
      end
      cur_len  = fold_next ? PER * DIV : PER;
      cur_skip = skip_next;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         wrap_up();
      end
   end

   initial begin
      int n, nst, h, bad;
      repeat (3) @(negedge clk);
      chk(!gate && !cyc_start && !skip && !hiccup, "R10", "outputs in reset",
          {gate, cyc_start, skip, hiccup}, 0);
      rst_n = 1'b1;
      en    = 1'b1;
      mon_on = 1'b1;

      run_period(50, 0, 0, "R2");
      run_period(2, 0, 0, "R3");
      run_period(8, 0, 0, "R3");
      run_period(-1, 0, 0, "R4");
      run_period(112, 0, 0, "R4");
      run_period(30, 1, 0, "R2");
      run_period(-1, 0, 1, "R5");
      run_period(300, 0, 1, "R6");
      run_period(-1, 0, 0, "R6");
      run_period(20, 0, 0, "R1");
      while (q.size() != 0) @(negedge clk);
      mon_on = 1'b0;

      // R7 / R8: persistent overcurrent
      do @(negedge clk); while (!cyc_start);
      ilim = 1'b1;
      n = 0;
      nst = 0;
      do begin
         @(negedge clk);
         n++;
         if (cyc_start) nst++;
      end while (!hiccup && n < 1000);
      chk(n == OCP * PER, "R7", "cycles to hiccup", n, OCP * PER);
      chk(nst == OCP - 1, "R7", "strobes before hiccup", nst, OCP - 1);
      ilim = 1'b0;
      h = 1;
      bad = 0;
      while (1) begin
         @(negedge clk);
         if (!hiccup) break;
         h++;
         if (gate || cyc_start) bad++;
      end
      chk(h == HIC, "R8", "hiccup length", h, HIC);
      chk(bad == 0, "R7", "activity during hiccup", bad, 0);
      chk(!cyc_start, "R8", "strobe in first cycle after hiccup", int'(cyc_start), 0);
      @(negedge clk);
      chk(cyc_start, "R8", "strobe after hiccup", int'(cyc_start), 1);

      // R9: enable control
      do @(negedge clk); while (!cyc_start);
      repeat (5) @(negedge clk);
      chk(gate, "R9", "gate mid pulse", int'(gate), 1);
      en = 1'b0;
      #1;
      chk(!gate, "R9", "gate after disable same cycle", int'(gate), 0);
      @(negedge clk);
      chk(!gate && !cyc_start, "R9", "quiet while disabled", {gate, cyc_start}, 0);
      en = 1'b1;
      @(negedge clk);
      chk(cyc_start, "R9", "strobe after re-enable", int'(cyc_start), 1);
      ilim = 1'b1;
      n = 0;
      while (!hiccup && n < 1000) begin
         @(negedge clk);
         n++;
      end
      ilim = 1'b0;
      repeat (10) @(negedge clk);
      chk(hiccup, "R9", "hiccup active before disable", int'(hiccup), 1);
      en = 1'b0;
      @(negedge clk);
      chk(!hiccup, "R9", "hiccup cleared by disable", int'(hiccup), 0);
      en = 1'b1;
      @(negedge clk);
      chk(cyc_start && gate, "R9", "restart after disable", {cyc_start, gate}, 3);

      wrap_up();
   end

endmodule